// File: doc/BRIEF.md
# Register-Pointer I2C Target

This block is an I2C target with one fixed 7-bit address. Through it, an external controller reads and writes a small internal register file. SCL and SDA are sampled with the system clock. The block finds START, repeated START and STOP on the sampled lines and shifts in the address byte. When the address matches, it acknowledges and then serves a write transfer or a read transfer. SDA is never driven high. The block only asserts an enable that pulls the line low, and an external pull-up supplies the high level.

A write transfer carries the register pointer in its first data byte. Every later data byte is stored at the pointed register, and the pointer then steps forward by one. A read transfer returns bytes starting at the current pointer and steps the pointer after each byte. It keeps going while the controller acknowledges. The pointer wraps from the last register to register 0, and it keeps its value across STOP. A typical random read is therefore: write the pointer, issue a repeated START, then read.

The controller FSM has these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address byte is being shifted in.
- `ST_ADDR_ACK`: the block is acknowledging the address.
- `ST_RX`: a pointer or data byte is being received.
- `ST_RX_ACK`: the block is acknowledging a received byte.
- `ST_TX`: a byte is being sent.
- `ST_TX_ACK`: the block is waiting for the controller's acknowledge.
- `ST_IGNORE`: the block has been dropped from the transfer.

The transitions are:
- START moves any state to `ST_ADDR`.
- STOP moves any state to `ST_IDLE`.
- At the eighth SCL fall, `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` on a mismatch.
- At the ninth SCL fall, `ST_ADDR_ACK` goes to `ST_RX` for a write and to `ST_TX` for a read.
- `ST_RX` and `ST_RX_ACK` alternate at each byte end.
- `ST_TX` goes to `ST_TX_ACK` at the byte end.
- At the ninth SCL fall, `ST_TX_ACK` goes back to `ST_TX` after an acknowledge and to `ST_IGNORE` after a not-acknowledge.

The system clock must run at least 16 times faster than SCL, which allows both 100 kHz and 400 kHz buses.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, the pull-low enable is deasserted, the pointer is 0 and every register holds 0x00.
- R2: A START (SDA falls while SCL is high) begins an address phase. After a STOP (SDA rises while SCL is high), clocked bits are ignored until the next START.
- R3: The address byte arrives MSB first as seven address bits followed by a direction bit (0 = write, 1 = read). Only address 1101000 is acknowledged. On a mismatch the block never pulls SDA low until the next START or STOP.
- R4: In a write transfer, the block acknowledges the address and every received byte by holding SDA low through the high period of the ninth clock.
- R5: In a write transfer, the first data byte loads the pointer (its low PTR_W bits). Each later byte is stored at the pointer, and the pointer then increments. The pointer keeps its value across STOP.
- R6: In a read transfer, bytes are sent MSB first starting at the current pointer. The pointer increments after each byte, and sending continues while the controller acknowledges.
- R7: After a not-acknowledge from the controller, SDA is released and stays released until the next START or STOP.
- R8: A repeated START without a preceding STOP ends the current transfer and starts a new address phase.
- R9: The pointer wraps from register 2**PTR_W-1 to register 0, for writes and for reads.
- R10: The pull-low enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The register write and the pointer wrap fall in the same cycle when a write burst starts at the last register. The byte end stores to register 2**PTR_W-1 and turns the pointer over to 0 in one update. A second write burst started at index 7 provokes this. The bench then reads back across the boundary and expects the two bytes at indices 7 and 0, followed by the untouched register 1. A second coincidence is the controller's not-acknowledge and the pointer step at the end of a read byte. The bench judges it by clocking further bytes after the not-acknowledge and requiring an all-ones line with no pull-low.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_q;
    logic [DEPTH-1:0] sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[DEPTH-2:0], scl_i};
            sda_q <= {sda_q[DEPTH-2:0], sda_i};
        end
    end

    // Current synchronized level at index DEPTH-2, previous at DEPTH-1.
    assign scl_lvl   = scl_q[DEPTH-2];
    assign sda_lvl   = sda_q[DEPTH-2];
    assign scl_rise  = scl_q[DEPTH-2] & ~scl_q[DEPTH-1];
    assign scl_fall  = ~scl_q[DEPTH-2] & scl_q[DEPTH-1];
    assign start_det = scl_q[DEPTH-2] & scl_q[DEPTH-1] & ~sda_q[DEPTH-2] & sda_q[DEPTH-1];
    assign stop_det  = scl_q[DEPTH-2] & scl_q[DEPTH-1] & sda_q[DEPTH-2] & ~sda_q[DEPTH-1];
endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
    parameter int DW    = 8,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [DW-1:0]    rd_data
);
    localparam int NREG = 1 << PTR_W;

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_addr == PTR_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    assign rd_data = regs[rd_addr];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101000,
    parameter int         PTR_W    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    tgt_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] sh_q, sh_d;
    logic [PTR_W-1:0]  ptr_q, ptr_d;
    logic              ptr_phase_q, ptr_phase_d;
    logic              mack_q, mack_d;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;
    logic              byte_end;

    i2c_line_sync #(.SYNC_STAGES(2)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_regfile #(.DW(BYTE_W), .PTR_W(PTR_W)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(ptr_q),
        .wr_data(sh_q),
        .rd_addr(ptr_q),
        .rd_data(rd_data)
    );

    assign byte_end = scl_fall && (cnt_q == CNT_W'(BYTE_W));

    // Next-state and datapath decisions
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        sh_d        = sh_q;
        ptr_d       = ptr_q;
        ptr_phase_d = ptr_phase_q;
        mack_d      = mack_q;
        wr_en       = 1'b0;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
                        cnt_d = cnt_q + 1'b1;
                    end else if (byte_end) begin
                        state_d = (sh_q[BYTE_W-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (sh_q[0]) begin
                            state_d = ST_TX;
                            sh_d    = rd_data;
                        end else begin
                            state_d     = ST_RX;
                            ptr_phase_d = 1'b1;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
                        cnt_d = cnt_q + 1'b1;
                    end else if (byte_end) begin
                        state_d = ST_RX_ACK;
                        if (ptr_phase_q) begin
                            ptr_d       = sh_q[PTR_W-1:0];
                            ptr_phase_d = 1'b0;
                        end else begin
                            wr_en = 1'b1;
                            ptr_d = ptr_q + 1'b1;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_RX;
                        cnt_d   = '0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt_d = cnt_q + 1'b1;
                    end else if (byte_end) begin
                        state_d = ST_TX_ACK;
                        ptr_d   = ptr_q + 1'b1;
                    end else if (scl_fall) begin
                        sh_d = {sh_q[BYTE_W-2:0], 1'b1};
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_d = ST_TX;
                            cnt_d   = '0;
                            sh_d    = rd_data;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            sh_q        <= '0;
            ptr_q       <= '0;
            ptr_phase_q <= 1'b0;
            mack_q      <= 1'b0;
        end else begin
            state_q     <= state_d;
            cnt_q       <= cnt_d;
            sh_q        <= sh_d;
            ptr_q       <= ptr_d;
            ptr_phase_q <= ptr_phase_d;
            mack_q      <= mack_d;
        end
    end

    // Outputs: pull-low enable decoded from registered state only
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_RX_ACK: sda_pull_o = 1'b1;
            ST_TX:                  sda_pull_o = ~sh_q[BYTE_W-1];
            default:                sda_pull_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_det,
    input logic       stop_det,
    input tgt_state_t state_q,
    input logic       sda_pull_o
);
    a_r2_start_opens_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state_q == ST_ADDR));

    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE));

    a_r3_silent_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_IGNORE || state_q == ST_ADDR) |-> !sda_pull_o);

    a_r4_ack_pull_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX_ACK || state_q == ST_ADDR_ACK) |-> sda_pull_o);

    a_r10_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> (!scl_lvl || $past(start_det || stop_det)));
endmodule

bind i2c_reg_target i2c_reg_target_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state_q   (state_q),
    .sda_pull_o(sda_pull_o)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb_top;
    localparam int CLK_P  = 10;
    localparam int Q      = 20;
    localparam int WDOG   = 150000;
    localparam logic [7:0] AW = 8'hD0;
    localparam logic [7:0] AR = 8'hD1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic pull;
    logic sda_line;
    int   checks = 0;
    int   fails = 0;
    int   pull_cnt = 0;
    int   r10_viol = 0;
    logic mon_en = 1'b0;
    logic prev_pull = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign sda_line = sda_m & ~pull;

    i2c_reg_target dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_pull_o(pull)
    );

    always @(negedge clk) begin
        if (mon_en && pull) pull_cnt++;
        if (rst_n && scl && (pull != prev_pull)) r10_viol++;
        prev_pull <= pull;
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        scl = 1'b0; hold(Q/2);
        sda_m = 1'b1; hold(Q/2);
        scl = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0; hold(Q/2);
        sda_m = 1'b0; hold(Q/2);
        scl = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; hold(Q/2);
            sda_m = b[i]; hold(Q/2);
            scl = 1'b1; hold(Q);
        end
        scl = 1'b0; hold(Q/2);
        sda_m = 1'b1; hold(Q/2);
        scl = 1'b1; hold(Q/2);
        ack = ~sda_line;
        hold(Q/2 - 1);
        ack = ack & ~sda_line;
        hold(1);
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; hold(Q/2);
            sda_m = 1'b1; hold(Q/2);
            scl = 1'b1; hold(Q/2);
            d[i] = sda_line;
            hold(Q/2);
        end
        scl = 1'b0; hold(Q/2);
        sda_m = ~give_ack; hold(Q/2);
        scl = 1'b1; hold(Q);
    endtask

    task automatic t_reset();
        bit ack;
        logic [7:0] d;
        chk(pull == 1'b0, "R1 pull released after reset", pull, 0);
        bus_start();
        wr_byte(AR, ack);
        chk(ack, "R3 read address acknowledged", ack, 1);
        rd_byte(1'b0, d);
        chk(d == 8'h00, "R1 register 0 cleared", d, 0);
        bus_stop();
    endtask

    task automatic t_write_read();
        bit ack;
        logic [7:0] d;
        bus_start();
        wr_byte(AW, ack); chk(ack, "R4 write address ack", ack, 1);
        wr_byte(8'h02, ack); chk(ack, "R4 pointer byte ack", ack, 1);
        wr_byte(8'hA5, ack); chk(ack, "R4 data byte ack", ack, 1);
        wr_byte(8'h3C, ack); chk(ack, "R4 second data ack", ack, 1);
        bus_stop();
        bus_start();
        wr_byte(AW, ack);
        wr_byte(8'h02, ack);
        bus_start();
        wr_byte(AR, ack); chk(ack, "R8 repeated START read address ack", ack, 1);
        rd_byte(1'b1, d); chk(d == 8'hA5, "R6 read reg2", d, 8'hA5);
        rd_byte(1'b0, d); chk(d == 8'h3C, "R5 auto-increment reg3", d, 8'h3C);
        bus_stop();
    endtask

    task automatic t_pointer_persist();
        bit ack;
        logic [7:0] d;
        bus_start();
        wr_byte(AW, ack); wr_byte(8'h05, ack); wr_byte(8'h99, ack);
        bus_stop();
        bus_start();
        wr_byte(AR, ack);
        rd_byte(1'b0, d); chk(d == 8'h00, "R5 pointer kept across STOP reads reg6", d, 0);
        bus_stop();
        bus_start();
        wr_byte(AW, ack); wr_byte(8'h05, ack);
        bus_stop();
        bus_start();
        wr_byte(AR, ack);
        rd_byte(1'b0, d); chk(d == 8'h99, "R6 read starts at current pointer reg5", d, 8'h99);
        bus_stop();
    endtask

    task automatic t_wrap();
        bit ack;
        logic [7:0] d;
        bus_start();
        wr_byte(AW, ack); wr_byte(8'h07, ack);
        wr_byte(8'hE1, ack); wr_byte(8'hE2, ack);
        chk(ack, "R9 ack after wrap write", ack, 1);
        bus_stop();
        bus_start();
        wr_byte(AW, ack); wr_byte(8'h07, ack);
        bus_start();
        wr_byte(AR, ack);
        rd_byte(1'b1, d); chk(d == 8'hE1, "R9 reg7", d, 8'hE1);
        rd_byte(1'b1, d); chk(d == 8'hE2, "R9 wrapped to reg0", d, 8'hE2);
        rd_byte(1'b0, d); chk(d == 8'h00, "R9 reg1 untouched", d, 0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        bit ack;
        logic [7:0] d;
        pull_cnt = 0;
        mon_en = 1'b1;
        bus_start();
        wr_byte(8'hA0, ack); chk(!ack, "R3 foreign address not acked", ack, 0);
        wr_byte(8'h00, ack);
        wr_byte(8'h55, ack);
        bus_stop();
        wr_byte(AW, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'h66, ack);
        mon_en = 1'b0;
        chk(pull_cnt == 0, "R3 R2 no pull while unaddressed", pull_cnt, 0);
        bus_stop();
        bus_start();
        wr_byte(AW, ack); wr_byte(8'h00, ack);
        bus_start();
        wr_byte(AR, ack);
        rd_byte(1'b0, d); chk(d == 8'hE2, "R2 R3 reg0 unchanged", d, 8'hE2);
        bus_stop();
    endtask

    task automatic t_nack();
        bit ack;
        logic [7:0] d;
        bus_start();
        wr_byte(AW, ack); wr_byte(8'h02, ack);
        bus_start();
        wr_byte(AR, ack);
        rd_byte(1'b0, d); chk(d == 8'hA5, "R7 byte before NACK", d, 8'hA5);
        pull_cnt = 0;
        mon_en = 1'b1;
        rd_byte(1'b1, d); chk(d == 8'hFF, "R7 line released after NACK", d, 8'hFF);
        rd_byte(1'b0, d);
        mon_en = 1'b0;
        chk(pull_cnt == 0, "R7 no pull after NACK", pull_cnt, 0);
        bus_stop();
    endtask

    initial begin
        hold(WDOG);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        hold(5);
        rst_n = 1'b1;
        hold(5);
        t_reset();
        t_write_read();
        t_pointer_persist();
        t_wrap();
        t_mismatch();
        t_nack();
        chk(r10_viol == 0, "R10 pull changed while SCL high", r10_viol, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule